// File: doc/BRIEF.md
# Bit-Layer Accumulator Row Array

This block computes one row of a convolution output with no multipliers. Each weight of a kernel is split into bit layers. The block sees one layer at a time, starting with the most significant. Within a layer every set bit arrives as a sign-only operation carrying three indices: a horizontal tap `j`, a kernel row `i` and a channel `z`. For each operation the block asks the external slice store for the pixel row at (`i`, `z`). That row comes back one clock later. The block then pads it with K/2 zero pixels on each side, takes the window shifted by `j`, and adds that window to all X lane accumulators at once, or subtracts it.

An end-of-run marker closes a layer. When lower layers still remain, every lane is doubled. The end-of-run that closes the last layer ends the row. A one-cycle `done` pulse then presents the finished lanes, which equal the integer dot product of the original multi-bit weights with the pixels, bias not included.

A small controller sequences the work through three states. `IDLE` waits for `start`. `RUN` accepts one operation per clock. `DRAIN` lets the last end-of-run pass through the pipeline. The transitions are `IDLE` to `RUN` on `start`, `RUN` to `DRAIN` when the end-of-run of the last layer is accepted, and `DRAIN` to `IDLE` unconditionally on the next clock.

Top module: `bitlayer_row_array`

## Requirements
- R1: `start` sampled in IDLE clears every lane to zero, which shows on `row_out` one clock later. It also arms the block for exactly NB layers and moves it to RUN.
- R2: An operation with `op_neg`=0 adds the selected unsigned pixels to the lanes and one with `op_neg`=1 subtracts them. Lanes are two's-complement signed values ACC_W bits wide.
- R3: Lane x receives fetched pixel x+j-K/2. It receives zero where that index falls outside 0..X-1. Pixel p of `rd_row` sits in bits [p*PIX_W +: PIX_W].
- R4: An accepted end-of-run (`op_eor`=1) with layers still remaining doubles every lane and adds no pixels.
- R5: The NB-th accepted end-of-run ends the row. `done` goes high for exactly one cycle, two clocks after that end-of-run is sampled. In that cycle `row_out` equals the sum over all weights w of w times the pixel selected per R3. A `start` sampled during that `done` cycle begins the next row.
- R6: One operation is accepted on every clock in RUN. Back-to-back operations and idle gaps (`op_valid`=0) both give the same result.
- R7: Operations presented outside RUN are ignored: they raise no read and leave `row_out` unchanged. A `start` presented while a row is in progress is ignored.
- R8: For each accepted operation that is not an end-of-run, `rd_en` is high in the same cycle with `rd_i`=`op_i` and `rd_z`=`op_z`. The block consumes `rd_row` on the following clock.
- R9: In IDLE with no `start`, `row_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new row (sampled in IDLE) |
| op_valid | input | 1 | Operation present this cycle |
| op_eor | input | 1 | Operation is an end-of-run marker |
| op_neg | input | 1 | Sign of the unit weight: 1 subtracts |
| op_j | input | clog2(K) | Horizontal tap index |
| op_i | input | clog2(K) | Kernel row index (slice selector) |
| op_z | input | clog2(Z) | Channel index |
| rd_en | output | 1 | Read request to the slice store |
| rd_i | output | clog2(K) | Slice selector of the read |
| rd_z | output | clog2(Z) | Channel of the read |
| rd_row | input | X*PIX_W | Pixel row returned one clock after `rd_en` |
| done | output | 1 | One-cycle pulse: row complete |
| row_out | output | X*ACC_W | Lane accumulators, lane x in [x*ACC_W +: ACC_W] |

## Verification
In the pipelined datapath, a new read for the next operation is issued in the same cycle as the previous operation's pixels are added. Likewise, a layer's doubling can land in the cycle right after that layer's last add. The bench triggers these overlaps by driving operations and end-of-run markers back-to-back with no gaps. A behavioural model then compares every lane, `rd_en` and `done` on every clock. A second overlap is the end of one row and the start of the next. The bench asserts `start` during the `done` cycle and checks that the finished row is still presented intact in that cycle, and that the lanes read zero on the next clock.

// File: rtl/blr_pkg.sv
package blr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } blr_state_e;
endpackage

// File: rtl/blr_window.sv
// Zero-padded window select: lane x takes pixel x+j-K/2 or zero.
module blr_window #(
    parameter int X     = 8,
    parameter int K     = 3,
    parameter int PIX_W = 8,
    parameter int JW    = 2
) (
    input  logic [X*PIX_W-1:0] row_i,
    input  logic [JW-1:0]      sel_j,
    output logic [X*PIX_W-1:0] win_o
);
    localparam int PAD   = K / 2;
    localparam int NTAPS = 1 << JW;

    for (genvar g = 0; g < X; g++) begin : g_lane
        logic [PIX_W-1:0] cand [NTAPS];
        for (genvar t = 0; t < NTAPS; t++) begin : g_tap
            localparam int E = g + t - PAD;
            if (t < K && E >= 0 && E < X) begin : g_in
                assign cand[t] = row_i[E*PIX_W +: PIX_W];
            end else begin : g_pad
                assign cand[t] = '0;
            end
        end
        assign win_o[g*PIX_W +: PIX_W] = cand[sel_j];
    end
endmodule

// File: rtl/blr_lane.sv
// One lane accumulator: clear, add/subtract an unsigned pixel, or double.
module blr_lane #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic             neg,
    input  logic             dbl,
    input  logic [PIX_W-1:0] pix,
    output logic [ACC_W-1:0] acc_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] ext;

    assign ext   = {{(ACC_W-PIX_W){1'b0}}, pix};
    assign acc_o = acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (add) begin
            acc_q <= neg ? (acc_q - ext) : (acc_q + ext);
        end else if (dbl) begin
            acc_q <= acc_q << 1;
        end
    end
endmodule

// File: rtl/blr_ctrl.sv
// Row sequencer: accepts operations, counts bit layers, stages one cycle.
module blr_ctrl
    import blr_pkg::*;
#(
    parameter int NB = 4,
    parameter int JW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_valid,
    input  logic          op_eor,
    input  logic          op_neg,
    input  logic [JW-1:0] op_j,
    output blr_state_e    state_o,
    output logic          rd_en,
    output logic          acc_clr,
    output logic          acc_add,
    output logic          acc_neg,
    output logic          acc_dbl,
    output logic [JW-1:0] sel_j,
    output logic          done
);
    localparam int LW = (NB > 1) ? $clog2(NB) : 1;

    blr_state_e    state, nxt;
    logic [LW-1:0] lcnt;
    logic          accept, last_layer;
    logic          p_valid, p_eor, p_more, p_neg;
    logic [JW-1:0] p_j;
    logic          done_q;

    assign accept     = (state == ST_RUN) && op_valid;
    assign last_layer = (lcnt == '0);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_RUN;
            ST_RUN:   if (accept && op_eor && last_layer) nxt = ST_DRAIN;
            ST_DRAIN: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lcnt    <= '0;
            p_valid <= 1'b0;
            p_eor   <= 1'b0;
            p_more  <= 1'b0;
            p_neg   <= 1'b0;
            p_j     <= '0;
            done_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                lcnt <= LW'(NB - 1);
            end else if (accept && op_eor && !last_layer) begin
                lcnt <= lcnt - 1'b1;
            end
            p_valid <= accept;
            p_eor   <= op_eor;
            p_more  <= !last_layer;
            p_neg   <= op_neg;
            p_j     <= op_j;
            done_q  <= p_valid && p_eor && !p_more;
        end
    end

    always_comb begin
        state_o = state;
        rd_en   = accept && !op_eor;
        acc_clr = (state == ST_IDLE) && start;
        acc_add = p_valid && !p_eor;
        acc_dbl = p_valid && p_eor && p_more;
        acc_neg = p_neg;
        sel_j   = p_j;
        done    = done_q;
    end
endmodule

// File: rtl/bitlayer_row_array.sv
module bitlayer_row_array
    import blr_pkg::*;
#(
    parameter int X     = 8,
    parameter int K     = 3,
    parameter int Z     = 4,
    parameter int NB    = 4,
    parameter int PIX_W = 8,
    parameter int ACC_W = 20,
    localparam int JW   = (K > 1) ? $clog2(K) : 1,
    localparam int ZW   = (Z > 1) ? $clog2(Z) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               op_valid,
    input  logic               op_eor,
    input  logic               op_neg,
    input  logic [JW-1:0]      op_j,
    input  logic [JW-1:0]      op_i,
    input  logic [ZW-1:0]      op_z,
    output logic               rd_en,
    output logic [JW-1:0]      rd_i,
    output logic [ZW-1:0]      rd_z,
    input  logic [X*PIX_W-1:0] rd_row,
    output logic               done,
    output logic [X*ACC_W-1:0] row_out
);
    blr_state_e       state;
    logic             acc_clr, acc_add, acc_neg, acc_dbl;
    logic [JW-1:0]    sel_j;
    logic [X*PIX_W-1:0] win;

    assign rd_i = op_i;
    assign rd_z = op_z;

    blr_ctrl #(.NB(NB), .JW(JW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_valid (op_valid),
        .op_eor   (op_eor),
        .op_neg   (op_neg),
        .op_j     (op_j),
        .state_o  (state),
        .rd_en    (rd_en),
        .acc_clr  (acc_clr),
        .acc_add  (acc_add),
        .acc_neg  (acc_neg),
        .acc_dbl  (acc_dbl),
        .sel_j    (sel_j),
        .done     (done)
    );

    blr_window #(.X(X), .K(K), .PIX_W(PIX_W), .JW(JW)) u_win (
        .row_i (rd_row),
        .sel_j (sel_j),
        .win_o (win)
    );

    for (genvar g = 0; g < X; g++) begin : g_acc
        blr_lane #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (acc_clr),
            .add   (acc_add),
            .neg   (acc_neg),
            .dbl   (acc_dbl),
            .pix   (win[g*PIX_W +: PIX_W]),
            .acc_o (row_out[g*ACC_W +: ACC_W])
        );
    end
endmodule

// File: rtl/bitlayer_row_array_chk.sv
module bitlayer_row_array_chk
    import blr_pkg::*;
#(
    parameter int X     = 8,
    parameter int ACC_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               op_valid,
    input logic               rd_en,
    input logic               done,
    input logic [X*ACC_W-1:0] row_out,
    input blr_state_e         state
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (row_out == '0));                    // R1
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                      // R5
    AST_DONE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_DRAIN));                                 // R5
    AST_READ_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> op_valid);                                                  // R8
    AST_NO_READ_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> !rd_en);                                        // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(row_out));                   // R9
endmodule

bind bitlayer_row_array bitlayer_row_array_chk #(.X(X), .ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_valid (op_valid),
    .rd_en    (rd_en),
    .done     (done),
    .row_out  (row_out),
    .state    (state)
);

// File: tb/tb_bitlayer_row_array.sv
module tb_bitlayer_row_array;
    localparam int X = 8, K = 3, Z = 4, NB = 4, PW = 8, AW = 20;
    localparam int JW = 2, ZW = 2, P = K / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic start = 0, op_valid = 0, op_eor = 0, op_neg = 0;
    logic [JW-1:0] op_j = '0, op_i = '0;
    logic [ZW-1:0] op_z = '0;
    logic rd_en, done;
    logic [JW-1:0] rd_i;
    logic [ZW-1:0] rd_z;
    logic [X*PW-1:0] rd_row = '0;
    logic [X*AW-1:0] row_out;

    bitlayer_row_array #(.X(X), .K(K), .Z(Z), .NB(NB), .PIX_W(PW), .ACC_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_valid(op_valid), .op_eor(op_eor),
        .op_neg(op_neg), .op_j(op_j), .op_i(op_i), .op_z(op_z), .rd_en(rd_en),
        .rd_i(rd_i), .rd_z(rd_z), .rd_row(rd_row), .done(done), .row_out(row_out)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int mem [K][Z][X];
    int wi [64], wj [64], wz [64], wv [64];
    int nw = 0;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pix(int i, int z, int e);
        if (e < 0 || e >= X) return 0;
        return mem[i][z][e];
    endfunction

    function automatic logic [X*PW-1:0] pack_row(int i, int z);
        logic [X*PW-1:0] r;
        for (int x = 0; x < X; x++) r[x*PW +: PW] = PW'(mem[i][z][x]);
        return r;
    endfunction

    function automatic longint lane(int x);
        return longint'($signed(row_out[x*AW +: AW]));
    endfunction

    // slice store with one clock of read latency
    always @(posedge clk) if (rd_en) rd_row <= pack_row(int'(rd_i), int'(rd_z));

    // behavioural reference model
    int mst = 0, mlc = 0, pj = 0, pi = 0, pz = 0;
    bit pv = 0, pe = 0, pm = 0, pn = 0, mdone = 0, took = 0;
    int macc [X];

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mlc = 0; pv = 0; mdone = 0;
            for (int x = 0; x < X; x++) macc[x] = 0;
        end else begin
            mdone = pv && pe && !pm;
            if (pv && !pe) begin
                for (int x = 0; x < X; x++) macc[x] += (pn ? -1 : 1) * pix(pi, pz, x + pj - P);
            end else if (pv && pe && pm) begin
                for (int x = 0; x < X; x++) macc[x] *= 2;
            end
            took = (mst == 1) && op_valid;
            pv = took;
            if (took) begin
                pe = op_eor; pm = (mlc != 0); pn = op_neg;
                pj = int'(op_j); pi = int'(op_i); pz = int'(op_z);
            end
            case (mst)
                0: if (start) begin
                    mst = 1; mlc = NB - 1;
                    for (int x = 0; x < X; x++) macc[x] = 0;
                end
                1: if (took && op_eor) begin
                    if (mlc == 0) mst = 2; else mlc--;
                end
                default: mst = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_rd;
            exp_rd = (mst == 1) && op_valid && !op_eor;
            chk(done === mdone, "R5 done timing vs model", done, mdone);
            for (int x = 0; x < X; x++)
                chk(lane(x) == macc[x], "R2 R3 R4 R6 lane vs model", lane(x), macc[x]);
            chk(rd_en === exp_rd, "R8 R7 read request vs model", rd_en, exp_rd);
            if (exp_rd) begin
                chk(int'(rd_i) == int'(op_i), "R8 rd_i", rd_i, op_i);
                chk(int'(rd_z) == int'(op_z), "R8 rd_z", rd_z, op_z);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL R5 watchdog actual=%0d expected<%0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    task automatic drive(bit s, bit v, bit e, bit n, int j, int i, int z);
        @(posedge clk); #1;
        start = s; op_valid = v; op_eor = e; op_neg = n;
        op_j = JW'(j); op_i = JW'(i); op_z = ZW'(z);
    endtask

    task automatic begin_row();
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        for (int x = 0; x < X; x++) chk(lane(x) == 0, "R1 start clears lane", lane(x), 0);
    endtask

    task automatic send_layers(bit bub, bit poke);
        for (int l = NB - 1; l >= 0; l--) begin
            for (int k = 0; k < nw; k++) begin
                int m;
                m = (wv[k] < 0) ? -wv[k] : wv[k];
                if (((m >> l) & 1) != 0) begin
                    if (bub && ($urandom % 3 == 0)) drive(0, 0, 0, 0, 0, 0, 0);
                    drive(poke && ($urandom % 4 == 0), 1, 0, wv[k] < 0, wj[k], wi[k], wz[k]);
                end
            end
            drive(0, 1, 1, 0, 0, 0, 0);
        end
    endtask

    task automatic finish_row(bit restart);
        int cnt;
        cnt = 0;
        @(posedge clk); #1;
        op_valid = 0; op_eor = 0; start = 0;
        while (cnt < 20) begin
            @(negedge clk);
            cnt++;
            if (done) break;
        end
        chk(cnt == 2, "R5 done two clocks after last end-of-run", cnt, 2);
        for (int x = 0; x < X; x++) begin
            longint r;
            r = 0;
            for (int k = 0; k < nw; k++) r += wv[k] * pix(wi[k], wz[k], x + wj[k] - P);
            chk(lane(x) == r, "R5 lane equals dot product", lane(x), r);
        end
        if (restart) start = 1;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < K; i++)
            for (int z = 0; z < Z; z++)
                for (int x = 0; x < X; x++) mem[i][z][x] = int'($urandom_range(0, 255));
    endtask

    task automatic rand_weights(int n);
        nw = n;
        for (int k = 0; k < n; k++) begin
            wv[k] = int'($urandom_range(0, 30)) - 15;
            if (wv[k] == 0) wv[k] = 7;
            wj[k] = int'($urandom % K); wi[k] = int'($urandom % K); wz[k] = int'($urandom % Z);
        end
    endtask

    initial begin
        longint saved [X];
        fill_mem();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0, "R1 done low after reset", done, 0);
        for (int x = 0; x < X; x++) chk(lane(x) == 0, "R1 lane zero after reset", lane(x), 0);
        rst_n = 1;

        // R3: tap 0 shifts right, lane 0 padded
        nw = 1; wv[0] = 1; wj[0] = 0; wi[0] = 0; wz[0] = 1;
        begin_row(); send_layers(0, 0); finish_row(0);
        chk(lane(0) == 0, "R3 left padding lane 0", lane(0), 0);

        // R2 R3: negative weight at last tap, right lane padded
        nw = 1; wv[0] = -1; wj[0] = K - 1; wi[0] = 2; wz[0] = 3;
        begin_row(); send_layers(0, 0); finish_row(0);
        chk(lane(X - 1) == 0, "R3 right padding last lane", lane(X - 1), 0);
        chk(lane(0) == -mem[2][3][1], "R2 subtract", lane(0), -mem[2][3][1]);

        // R4: most significant layer doubled NB-1 times; restart in done cycle
        nw = 1; wv[0] = 8; wj[0] = 1; wi[0] = 1; wz[0] = 2;
        begin_row(); send_layers(0, 0); finish_row(1);
        chk(lane(3) == 8 * mem[1][2][3], "R4 doubling of top layer", lane(3), 8 * mem[1][2][3]);

        // R5 R6: immediate restart, dense random row back-to-back
        rand_weights(24);
        send_layers(0, 0); finish_row(0);

        // R6 R7: gaps and stray start pulses mid-row
        for (int r = 0; r < 3; r++) begin
            fill_mem(); rand_weights(16 + r * 8);
            begin_row(); send_layers(1, 1); finish_row(0);
        end

        // R7 R9: operations in IDLE are ignored, result holds
        for (int x = 0; x < X; x++) saved[x] = lane(x);
        for (int c = 0; c < 3; c++) begin
            drive(0, 1, 0, c[0], 1, 1, 1);
            @(negedge clk);
            chk(rd_en === 1'b0, "R7 no read in IDLE", rd_en, 0);
            for (int x = 0; x < X; x++) chk(lane(x) == saved[x], "R9 R7 hold in IDLE", lane(x), saved[x]);
        end
        drive(0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule